// File: doc/BRIEF.md
# Calendar Real-Time Clock Counter

This block keeps wall-clock time and a calendar for the years 2000 through 2099. Seconds, minutes, hours, day of month, month and a two-digit year are held as BCD bytes; a day-of-week counter runs beside them. A tick from a slow oscillator is divided by a two-stage prescaler. The first stage counts ticks up to half a second. The second stage is a single bit, visible at the ports, that marks the second half of each second. When the second completes, the seconds field steps and a carry ripples up through the calendar.

Each field can be loaded through its own write strobe and a shared data byte. The new value appears right after the strobe's clock edge, and counting carries on from there. Loading seconds or minutes also resets both prescaler stages, which lets software line up the second boundary with an outside reference. A sync flag warns of a coming rollover a fixed number of ticks before it happens. A one-cycle pulse marks each completed second.

Top module: `calClock`

## Requirements
- R1: After reset the fields read year 00, month 01, day 01, weekday 0, hour 00, minute 00, second 00, and halfSec, syncFlag and secPulse are all 0.
- R2: With enable high, each tick advances the prescaler. halfSec rises after HALF_TICKS ticks. After 2*HALF_TICKS ticks, seconds steps by one, halfSec returns to 0 and secPulse is high for exactly one cycle. With enable low, ticks are ignored.
- R3: Seconds and minutes are BCD 00..59 and wrap from 59 to 00 with a carry. Hours are BCD 00..23 and wrap from 23 to 00 with a carry into the day.
- R4: Weekday is a 3-bit value 0..6. It steps on each hour carry and wraps from 6 to 0.
- R5: Day of month is BCD and wraps to 01 with a month carry after its last day. Months 04, 06, 09 and 11 have 30 days. February has 29 days in a leap year and 28 otherwise. All other months have 31.
- R6: The year is BCD 00..99, meaning 2000..2099. A year is a leap year exactly when its value is divisible by 4, so 00 is a leap year. Month wraps from 12 to 01 with a year carry, and year wraps from 99 to 00.
- R7: A field strobe loads wrData (weekday takes wrData[2:0]) at that clock edge. The value is visible in the next cycle, and counting continues from it.
- R8: A seconds or minutes write resets the tick prescaler and halfSec to zero. Such a write also suppresses a seconds increment due in the same cycle, so the next increment comes 2*HALF_TICKS ticks later. Writes to other fields leave the prescaler and halfSec untouched.
- R9: syncFlag is high while halfSec is 1 and at most SYNC_LEAD ticks remain before the increment, and in the secPulse cycle. It is low at all other times.
- R10: When a write to a field coincides with a carry into that field, the written value wins and no carry passes on from that field.
- R11: With enable low, writes still load fields, and the time does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Counting enable |
| tick | input | 1 | Time-base tick, one cycle per oscillator period |
| wrData | input | 8 | Shared write data (BCD) |
| wrSeconds | input | 1 | Load seconds |
| wrMinutes | input | 1 | Load minutes |
| wrHours | input | 1 | Load hours |
| wrWeekday | input | 1 | Load weekday from wrData[2:0] |
| wrDay | input | 1 | Load day of month |
| wrMonth | input | 1 | Load month |
| wrYear | input | 1 | Load year |
| seconds | output | 8 | BCD seconds |
| minutes | output | 8 | BCD minutes |
| hours | output | 8 | BCD hours |
| weekday | output | 3 | Day of week 0..6 |
| dayOfMonth | output | 8 | BCD day |
| month | output | 8 | BCD month |
| year | output | 8 | BCD year within 2000..2099 |
| halfSec | output | 1 | Second-half indicator, read-only |
| syncFlag | output | 1 | Rollover-imminent window |
| secPulse | output | 1 | One-cycle pulse per completed second |

## Verification
A wrong prescaler count shows up as a halfSec edge, syncFlag window or secPulse that lands a cycle off from the bench's timeline. Such an error is visible within one second's worth of ticks. A wrong month-length or leap decision stays hidden until a day carry. The bench therefore loads 23:59:59 on the last day of chosen months and years, so the error shows at the very next increment. A broken carry gate or collision priority shows at the single edge where a write and an increment meet, and the bench aims a write at exactly that edge.

// File: rtl/calPkg.sv
package calPkg;

  typedef struct packed {
    logic incSec;
  } calStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic isLeap(input logic [7:0] yearBcd);
    logic [4:0] s;
    s = {yearBcd[7:4], 1'b0} + {1'b0, yearBcd[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] monthLength(input logic [7:0] monthBcd,
                                             input logic [7:0] yearBcd);
    case (monthBcd)
      8'h02:                      return isLeap(yearBcd) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/calBcdField.sv
module calBcdField #(
  parameter logic [7:0] RST_VAL = 8'h00,
  parameter logic [7:0] LOW_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       carryIn,
  input  logic [7:0] limit,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] value,
  output logic       carryOut
);
  import calPkg::*;

  logic atLimit;
  assign atLimit  = (value >= limit);
  assign carryOut = carryIn && !wrEn && atLimit;

  always_ff @(posedge clk) begin
    if (!rstN)        value <= RST_VAL;
    else if (wrEn)    value <= wrData;
    else if (carryIn) value <= atLimit ? LOW_VAL : bcdInc(value);
  end

  // R7: a load shows the written byte next cycle
  a_r7_write_load: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> value == $past(wrData));
  // R3: stepping at the limit wraps to the low value
  a_r3_wrap_low: assert property (@(posedge clk) disable iff (!rstN)
    carryIn && !wrEn && value >= limit |=> value == LOW_VAL);
  // R10: a write coinciding with a carry keeps the written value
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    carryIn && wrEn |=> value == $past(wrData));

endmodule

// File: rtl/calCtrl.sv
module calCtrl
  import calPkg::*;
#(
  parameter int HALF_TICKS = 16384,
  parameter int SYNC_LEAD  = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       tick,
  input  logic       wrSeconds,
  input  logic       wrMinutes,
  output calStrobe_t strobe,
  output logic       halfSec,
  output logic       syncFlag,
  output logic       secPulse
);
  localparam int CW = (HALF_TICKS > 2) ? $clog2(HALF_TICKS) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(HALF_TICKS - 1);
  localparam logic [CW-1:0] SYNC_THR = CW'(HALF_TICKS - SYNC_LEAD);

  logic [CW-1:0] preCnt;
  logic clrPre, stepTick, lastTick, wrapSec;

  assign clrPre   = wrSeconds || wrMinutes;
  assign stepTick = enable && tick && !clrPre;
  assign lastTick = (preCnt == LAST_CNT);
  assign wrapSec  = stepTick && lastTick && halfSec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      halfSec <= 1'b0;
    end else if (clrPre) begin
      preCnt  <= '0;
      halfSec <= 1'b0;
    end else if (stepTick) begin
      if (lastTick) begin
        preCnt  <= '0;
        halfSec <= !halfSec;
      end else begin
        preCnt  <= preCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) secPulse <= 1'b0;
    else       secPulse <= wrapSec;
  end

  assign strobe.incSec = wrapSec;
  assign syncFlag      = (halfSec && (preCnt >= SYNC_THR)) || secPulse;

  // R8: seconds/minutes write empties both prescaler stages
  a_r8_prescale_clear: assert property (@(posedge clk) disable iff (!rstN)
    clrPre |=> preCnt == '0 && !halfSec);
  // R2: disabled prescaler does not move
  a_r2_hold_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable && !clrPre |=> $stable(preCnt) && $stable(halfSec));
  // R2: the second pulse lasts one cycle
  a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    secPulse |=> !secPulse);
  // R9: the warning window is open just before each increment
  a_r9_sync_lead: assert property (@(posedge clk) disable iff (!rstN)
    $rose(secPulse) |-> $past(syncFlag));

endmodule

// File: rtl/calDatapath.sv
module calDatapath
  import calPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  calStrobe_t strobe,
  input  logic [7:0] wrData,
  input  logic       wrSeconds,
  input  logic       wrMinutes,
  input  logic       wrHours,
  input  logic       wrWeekday,
  input  logic       wrDay,
  input  logic       wrMonth,
  input  logic       wrYear,
  output logic [7:0] seconds,
  output logic [7:0] minutes,
  output logic [7:0] hours,
  output logic [2:0] weekday,
  output logic [7:0] dayOfMonth,
  output logic [7:0] month,
  output logic [7:0] year
);
  logic cMin, cHour, cDay, cMonth, cYear, yearWrap;
  logic [7:0] dayLimit;

  assign dayLimit = monthLength(month, year);

  calBcdField #(.RST_VAL(8'h00), .LOW_VAL(8'h00)) uSec (
    .clk(clk), .rstN(rstN), .carryIn(strobe.incSec), .limit(8'h59),
    .wrEn(wrSeconds), .wrData(wrData), .value(seconds), .carryOut(cMin));

  calBcdField #(.RST_VAL(8'h00), .LOW_VAL(8'h00)) uMin (
    .clk(clk), .rstN(rstN), .carryIn(cMin), .limit(8'h59),
    .wrEn(wrMinutes), .wrData(wrData), .value(minutes), .carryOut(cHour));

  calBcdField #(.RST_VAL(8'h00), .LOW_VAL(8'h00)) uHour (
    .clk(clk), .rstN(rstN), .carryIn(cHour), .limit(8'h23),
    .wrEn(wrHours), .wrData(wrData), .value(hours), .carryOut(cDay));

  calBcdField #(.RST_VAL(8'h01), .LOW_VAL(8'h01)) uDay (
    .clk(clk), .rstN(rstN), .carryIn(cDay), .limit(dayLimit),
    .wrEn(wrDay), .wrData(wrData), .value(dayOfMonth), .carryOut(cMonth));

  calBcdField #(.RST_VAL(8'h01), .LOW_VAL(8'h01)) uMonth (
    .clk(clk), .rstN(rstN), .carryIn(cMonth), .limit(8'h12),
    .wrEn(wrMonth), .wrData(wrData), .value(month), .carryOut(cYear));

  calBcdField #(.RST_VAL(8'h00), .LOW_VAL(8'h00)) uYear (
    .clk(clk), .rstN(rstN), .carryIn(cYear), .limit(8'h99),
    .wrEn(wrYear), .wrData(wrData), .value(year), .carryOut(yearWrap));

  always_ff @(posedge clk) begin
    if (!rstN)          weekday <= 3'd0;
    else if (wrWeekday) weekday <= wrData[2:0];
    else if (cDay)      weekday <= (weekday >= 3'd6) ? 3'd0 : weekday + 3'd1;
  end

  // R4: weekday wraps from 6 to 0 on a day carry
  a_r4_weekday_wrap: assert property (@(posedge clk) disable iff (!rstN)
    cDay && !wrWeekday && weekday == 3'd6 |=> weekday == 3'd0);
  // R6: the century wraps back to 00
  a_r6_century_wrap: assert property (@(posedge clk) disable iff (!rstN)
    yearWrap && !wrYear |=> year == 8'h00);
  // R5: February of a year divisible by 4 reaches the 29th
  a_r5_leap_feb: assert property (@(posedge clk) disable iff (!rstN)
    cDay && !wrDay && !wrMonth && !wrYear && month == 8'h02 && dayOfMonth == 8'h28
      && year[4] == year[1] && year[0] == 1'b0
    |=> dayOfMonth == 8'h29);

endmodule

// File: rtl/calClock.sv
module calClock
  import calPkg::*;
#(
  parameter int HALF_TICKS = 16384,
  parameter int SYNC_LEAD  = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       tick,
  input  logic [7:0] wrData,
  input  logic       wrSeconds,
  input  logic       wrMinutes,
  input  logic       wrHours,
  input  logic       wrWeekday,
  input  logic       wrDay,
  input  logic       wrMonth,
  input  logic       wrYear,
  output logic [7:0] seconds,
  output logic [7:0] minutes,
  output logic [7:0] hours,
  output logic [2:0] weekday,
  output logic [7:0] dayOfMonth,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic       halfSec,
  output logic       syncFlag,
  output logic       secPulse
);
  calStrobe_t strobe;

  calCtrl #(.HALF_TICKS(HALF_TICKS), .SYNC_LEAD(SYNC_LEAD)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .tick(tick),
    .wrSeconds(wrSeconds), .wrMinutes(wrMinutes), .strobe(strobe),
    .halfSec(halfSec), .syncFlag(syncFlag), .secPulse(secPulse));

  calDatapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .wrSeconds(wrSeconds), .wrMinutes(wrMinutes), .wrHours(wrHours),
    .wrWeekday(wrWeekday), .wrDay(wrDay), .wrMonth(wrMonth), .wrYear(wrYear),
    .seconds(seconds), .minutes(minutes), .hours(hours), .weekday(weekday),
    .dayOfMonth(dayOfMonth), .month(month), .year(year));

endmodule

// File: tb/sim_calClock.sv
module sim_calClock;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int LEAD = 2;
  localparam int SEL_SEC = 0, SEL_MIN = 1, SEL_HOUR = 2, SEL_WDAY = 3,
                 SEL_DAY = 4, SEL_MON = 5, SEL_YEAR = 6;

  logic clk = 1'b0;
  logic rstN, enable, tick;
  logic [7:0] wrData;
  logic wrSeconds, wrMinutes, wrHours, wrWeekday, wrDay, wrMonth, wrYear;
  logic [7:0] seconds, minutes, hours, dayOfMonth, month, year;
  logic [2:0] weekday;
  logic halfSec, syncFlag, secPulse;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    string req;
    logic [53:0] v;
  } expItem_t;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  calClock #(.HALF_TICKS(HALF), .SYNC_LEAD(LEAD)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .tick(tick), .wrData(wrData),
    .wrSeconds(wrSeconds), .wrMinutes(wrMinutes), .wrHours(wrHours),
    .wrWeekday(wrWeekday), .wrDay(wrDay), .wrMonth(wrMonth), .wrYear(wrYear),
    .seconds(seconds), .minutes(minutes), .hours(hours), .weekday(weekday),
    .dayOfMonth(dayOfMonth), .month(month), .year(year),
    .halfSec(halfSec), .syncFlag(syncFlag), .secPulse(secPulse));

  // monitor: compares observed ports with queued expectations
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        expItem_t it;
        logic [53:0] obs;
        it  = expQ.pop_front();
        obs = {year, month, dayOfMonth, weekday, hours, minutes, seconds,
               halfSec, syncFlag, secPulse};
        checks++;
        if (obs !== it.v) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.req, obs, it.v);
        end
      end
    end
  end

  task automatic pushExp(input string req, input logic [7:0] y, mo, d,
                         input logic [2:0] wd, input logic [7:0] h, mi, s,
                         input logic hs, sy, pu);
    expItem_t it;
    it.req = req;
    it.v   = {y, mo, d, wd, h, mi, s, hs, sy, pu};
    expQ.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int sel, input logic [7:0] d);
    wrData = d;
    case (sel)
      SEL_SEC:  wrSeconds = 1'b1;
      SEL_MIN:  wrMinutes = 1'b1;
      SEL_HOUR: wrHours   = 1'b1;
      SEL_WDAY: wrWeekday = 1'b1;
      SEL_DAY:  wrDay     = 1'b1;
      SEL_MON:  wrMonth   = 1'b1;
      default:  wrYear    = 1'b1;
    endcase
    @(posedge clk);
    #1;
    {wrSeconds, wrMinutes, wrHours, wrWeekday, wrDay, wrMonth, wrYear} = '0;
  endtask

  task automatic setTime(input logic [7:0] y, mo, d, input logic [2:0] wd,
                         input logic [7:0] h, mi, s);
    enable = 1'b0;
    wr(SEL_YEAR, y);
    wr(SEL_MON, mo);
    wr(SEL_DAY, d);
    wr(SEL_WDAY, {5'd0, wd});
    wr(SEL_HOUR, h);
    wr(SEL_MIN, mi);
    wr(SEL_SEC, s);
    enable = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; tick = 1'b1; wrData = '0;
    {wrSeconds, wrMinutes, wrHours, wrWeekday, wrDay, wrMonth, wrYear} = '0;
    step(3);
    rstN = 1'b1;
    pushExp("R1 reset", 8'h00, 8'h01, 8'h01, 3'd0, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    step(10);
    pushExp("R11 disabled ticks", 8'h00, 8'h01, 8'h01, 3'd0, 8'h00, 8'h00, 8'h00, 0, 0, 0);

    enable = 1'b1;
    step(3);
    pushExp("R2 first half", 8'h00, 8'h01, 8'h01, 3'd0, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    step(1);
    pushExp("R2 halfSec rise", 8'h00, 8'h01, 8'h01, 3'd0, 8'h00, 8'h00, 8'h00, 1, 0, 0);
    step(2);
    pushExp("R9 sync lead", 8'h00, 8'h01, 8'h01, 3'd0, 8'h00, 8'h00, 8'h00, 1, 1, 0);
    step(2);
    pushExp("R2 second step", 8'h00, 8'h01, 8'h01, 3'd0, 8'h00, 8'h00, 8'h01, 0, 1, 1);
    step(1);
    pushExp("R9 sync drop", 8'h00, 8'h01, 8'h01, 3'd0, 8'h00, 8'h00, 8'h01, 0, 0, 0);

    // R3 R4 R6 full rollover
    setTime(8'h99, 8'h12, 8'h31, 3'd6, 8'h23, 8'h59, 8'h59);
    step(7);
    pushExp("R7 loaded hold", 8'h99, 8'h12, 8'h31, 3'd6, 8'h23, 8'h59, 8'h59, 1, 1, 0);
    step(1);
    pushExp("R6 century wrap", 8'h00, 8'h01, 8'h01, 3'd0, 8'h00, 8'h00, 8'h00, 0, 1, 1);

    setTime(8'h05, 8'h03, 8'h10, 3'd2, 8'h10, 8'h59, 8'h59);
    step(8);
    pushExp("R3 hour carry", 8'h05, 8'h03, 8'h10, 3'd2, 8'h11, 8'h00, 8'h00, 0, 1, 1);

    setTime(8'h23, 8'h04, 8'h30, 3'd1, 8'h23, 8'h59, 8'h59);
    step(8);
    pushExp("R5 30-day month", 8'h23, 8'h05, 8'h01, 3'd2, 8'h00, 8'h00, 8'h00, 0, 1, 1);

    setTime(8'h23, 8'h02, 8'h28, 3'd3, 8'h23, 8'h59, 8'h59);
    step(8);
    pushExp("R5 feb common", 8'h23, 8'h03, 8'h01, 3'd4, 8'h00, 8'h00, 8'h00, 0, 1, 1);

    setTime(8'h24, 8'h02, 8'h28, 3'd3, 8'h23, 8'h59, 8'h59);
    step(8);
    pushExp("R6 leap 24 feb 29", 8'h24, 8'h02, 8'h29, 3'd4, 8'h00, 8'h00, 8'h00, 0, 1, 1);

    setTime(8'h24, 8'h02, 8'h29, 3'd4, 8'h23, 8'h59, 8'h59);
    step(8);
    pushExp("R5 leap feb end", 8'h24, 8'h03, 8'h01, 3'd5, 8'h00, 8'h00, 8'h00, 0, 1, 1);

    setTime(8'h00, 8'h02, 8'h28, 3'd0, 8'h23, 8'h59, 8'h59);
    step(8);
    pushExp("R6 year 00 leap", 8'h00, 8'h02, 8'h29, 3'd1, 8'h00, 8'h00, 8'h00, 0, 1, 1);

    setTime(8'h25, 8'h01, 8'h30, 3'd5, 8'h23, 8'h59, 8'h59);
    step(8);
    pushExp("R5 31-day month", 8'h25, 8'h01, 8'h31, 3'd6, 8'h00, 8'h00, 8'h00, 0, 1, 1);

    setTime(8'h30, 8'h06, 8'h15, 3'd3, 8'h12, 8'h34, 8'h42);
    step(8);
    pushExp("R7 count on", 8'h30, 8'h06, 8'h15, 3'd3, 8'h12, 8'h34, 8'h43, 0, 1, 1);
    step(8);
    pushExp("R7 count on 2", 8'h30, 8'h06, 8'h15, 3'd3, 8'h12, 8'h34, 8'h44, 0, 1, 1);

    setTime(8'h30, 8'h06, 8'h15, 3'd3, 8'h12, 8'h34, 8'h00);
    step(4);
    pushExp("R8 half reached", 8'h30, 8'h06, 8'h15, 3'd3, 8'h12, 8'h34, 8'h00, 1, 0, 0);
    wr(SEL_HOUR, 8'h13);
    pushExp("R8 hour write keeps half", 8'h30, 8'h06, 8'h15, 3'd3, 8'h13, 8'h34, 8'h00, 1, 0, 0);
    wr(SEL_MIN, 8'h40);
    pushExp("R8 minute write clears", 8'h30, 8'h06, 8'h15, 3'd3, 8'h13, 8'h40, 8'h00, 0, 0, 0);
    step(8);
    pushExp("R8 realigned second", 8'h30, 8'h06, 8'h15, 3'd3, 8'h13, 8'h40, 8'h01, 0, 1, 1);

    setTime(8'h30, 8'h06, 8'h15, 3'd3, 8'h12, 8'h34, 8'h10);
    step(7);
    wr(SEL_SEC, 8'h20);
    pushExp("R8 sec write beats step", 8'h30, 8'h06, 8'h15, 3'd3, 8'h12, 8'h34, 8'h20, 0, 0, 0);
    step(8);
    pushExp("R8 next step", 8'h30, 8'h06, 8'h15, 3'd3, 8'h12, 8'h34, 8'h21, 0, 1, 1);

    setTime(8'h30, 8'h06, 8'h15, 3'd3, 8'h05, 8'h59, 8'h59);
    step(7);
    wr(SEL_HOUR, 8'h10);
    pushExp("R10 hour write wins", 8'h30, 8'h06, 8'h15, 3'd3, 8'h10, 8'h00, 8'h00, 0, 1, 1);

    enable = 1'b0;
    wr(SEL_SEC, 8'h05);
    step(20);
    pushExp("R11 write while disabled", 8'h30, 8'h06, 8'h15, 3'd3, 8'h10, 8'h00, 8'h05, 0, 0, 0);

    step(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule